// File: doc/BRIEF.md
# Two-Wire Display Slave with Control-Byte Framing

This block is the two-wire serial (I2C) slave front end of a small display controller. It watches the clock and data lines in the system clock domain, recognises bus START and STOP conditions and answers to one 7-bit device address. Bit 0 of that address comes from a static strap pin. Every byte the slave accepts is acknowledged by driving the data line low through the ninth clock. The open-drain data line is modelled as an output enable.

In a write, each byte after the address is parsed as a control byte or as a payload byte. A control byte sets two things: whether exactly one payload byte follows before the next control byte, or every remaining byte is payload; and whether payload goes to the command decoder or into display RAM. Payload bytes leave the block as single-cycle pulses on a command port or a RAM-write port.

In a read, the slave starts shifting bytes out right after acknowledging the address. It fetches each byte through a request/response port. A select output reports the RAM/command choice from the most recent control byte, so the surrounding logic can return RAM data or status. Reads continue while the master acknowledges and stop at the first byte the master does not acknowledge.

Top module: `i2c_disp_slave`

## Requirements
- R1: The slave answers only to the address whose upper six bits are 011110 and whose bit 0 equals `addr_lsb`. Bit 0 of the address byte is R/W (1 = read). A non-matching address byte is not acknowledged, and nothing is acknowledged or delivered until the next START.
- R2: START is the data line falling while the clock line is high. STOP is the data line rising while the clock line is high. A START in any state, including a repeated START, makes the next byte an address byte and the next write byte a control byte. STOP returns the slave to idle.
- R3: The slave holds `sda_oe` high for the whole high phase of the ninth clock after the address byte and after every write byte, but only while it is addressed. It changes `sda_oe` only while the clock line is low.
- R4: A control byte has the continuation bit in bit 7 and the route bit in bit 6. When bit 7 is 1, exactly one payload byte follows, and the byte after it is again a control byte.
- R5: When bit 7 of a control byte is 0, every following byte up to the next STOP or START is a payload byte.
- R6: A payload byte is delivered as a one-cycle pulse on `ram_valid` with the byte on `ram_byte` when the route bit is 1. When the route bit is 0 it goes to `cmd_valid` and `cmd_byte` instead. The two pulses never coincide, and bytes come out in bus order.
- R7: In a read, `rd_req` pulses for one cycle as each byte is loaded, and `rd_data` is captured in that cycle. The byte is sent MSB first, and `sda_oe` is high for each 0 bit. `rd_sel_ram` holds the route bit of the most recent control byte.
- R8: When the master acknowledges a read byte, the next byte is fetched and sent. When it does not acknowledge, the slave releases the data line and makes no further `rd_req` until the next START.
- R9: After reset, `sda_oe`, `cmd_valid`, `ram_valid`, `rd_req` and `rd_sel_ram` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_lsb | input | 1 | Strap that sets bit 0 of the device address |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| cmd_valid | output | 1 | One-cycle pulse: payload byte for the command decoder |
| cmd_byte | output | 8 | Command payload byte |
| ram_valid | output | 1 | One-cycle pulse: payload byte for display RAM |
| ram_byte | output | 8 | RAM payload byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_sel_ram | output | 1 | Route bit of the last control byte (1 = RAM, 0 = status) |
| rd_data | input | 8 | Read byte, captured in the cycle `rd_req` is high |

## Verification
Directed frames separate the two framing modes: alternating control/payload pairs, an unbroken stream, and a repeated START in the middle of a stream. A decoder that mixes up bit 7 and bit 6, or that does not reset its parser on a repeated START, delivers a different byte sequence than the model. Address bytes with both strap values, plus mismatching addresses, show whether acknowledge and delivery depend on the exact match. Reads that end with a master NACK, followed by extra clocks, show whether the line is released and requests stop. Random frames of random raw bytes, at random lengths and with occasional reads, are compared against a bench model of the parser, so that arbitrary mixes of the two modes and the two routes are covered.

// File: rtl/i2c_disp_pkg.sv
package i2c_disp_pkg;
  parameter int BYTE_W = 8;
  parameter int SYNC_STAGES = 2;
  parameter logic [5:0] DEV_ADDR_HI = 6'b011110;

  typedef enum logic [2:0] {
    EG_IDLE,
    EG_RX,
    EG_ACKW,
    EG_ACK,
    EG_TX,
    EG_MACK,
    EG_MACKF
  } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_disp_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter logic [5:0] ADDR_HI = DEV_ADDR_HI
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         addr_lsb,
  input  logic         scl_lvl,
  input  logic         sda_lvl,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         start_det,
  input  logic         stop_det,
  input  logic [W-1:0] rd_data,
  output logic         sda_oe,
  output logic         rd_req,
  output logic         wr_valid,
  output logic [W-1:0] wr_byte,
  output logic         frame_start
);
  localparam int CNT_W = $clog2(W + 1);

  eng_state_t       st;
  logic [CNT_W-1:0] bitcnt;
  logic [W-1:0]     rx_sr, tx_sr, rx_full;
  logic             addr_phase, reading;

  assign rx_full = {rx_sr[W-2:0], sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= EG_IDLE;
      bitcnt      <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      addr_phase  <= 1'b0;
      reading     <= 1'b0;
      sda_oe      <= 1'b0;
      rd_req      <= 1'b0;
      wr_valid    <= 1'b0;
      wr_byte     <= '0;
      frame_start <= 1'b0;
    end else begin
      rd_req      <= 1'b0;
      wr_valid    <= 1'b0;
      frame_start <= 1'b0;
      if (stop_det) begin
        st     <= EG_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st          <= EG_RX;
        bitcnt      <= '0;
        addr_phase  <= 1'b1;
        reading     <= 1'b0;
        sda_oe      <= 1'b0;
        frame_start <= 1'b1;
      end else begin
        unique case (st)
          EG_IDLE: ;
          EG_RX: if (scl_rise) begin
            rx_sr  <= rx_full;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(W - 1)) begin
              if (addr_phase) begin
                if (rx_full[W-1:1] == {ADDR_HI, addr_lsb}) begin
                  reading    <= rx_full[0];
                  addr_phase <= 1'b0;
                  st         <= EG_ACKW;
                end else begin
                  st <= EG_IDLE;
                end
              end else begin
                wr_valid <= 1'b1;
                wr_byte  <= rx_full;
                st       <= EG_ACKW;
              end
            end
          end
          EG_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= EG_ACK;
          end
          EG_ACK, EG_MACKF: if (scl_fall) begin
            bitcnt <= '0;
            if (reading) begin
              rd_req <= 1'b1;
              tx_sr  <= rd_data;
              sda_oe <= ~rd_data[W-1];
              st     <= EG_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= EG_RX;
            end
          end
          EG_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == CNT_W'(W)) begin
                sda_oe <= 1'b0;
                st     <= EG_MACK;
              end else begin
                tx_sr  <= tx_sr << 1;
                sda_oe <= ~tx_sr[W-2];
              end
            end
          end
          EG_MACK: if (scl_rise) begin
            st <= sda_lvl ? EG_IDLE : EG_MACKF;
          end
          default: st <= EG_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == EG_IDLE) |-> !sda_oe); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == EG_IDLE)); // R2
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == EG_RX && bitcnt == '0 && addr_phase)); // R2
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl); // R3
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R7
  AST_NACK_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (st == EG_IDLE) |-> !rd_req); // R8
endmodule

// File: rtl/ctl_stream_parser.sv
module ctl_stream_parser
  import i2c_disp_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_byte,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_byte,
  output logic         ram_valid,
  output logic [W-1:0] ram_byte,
  output logic         dc_last
);
  localparam int CO_BIT = W - 1;
  localparam int DC_BIT = W - 2;

  logic want_ctl, streaming;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_ctl  <= 1'b1;
      streaming <= 1'b0;
      dc_last   <= 1'b0;
      cmd_valid <= 1'b0;
      ram_valid <= 1'b0;
      cmd_byte  <= '0;
      ram_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      ram_valid <= 1'b0;
      if (frame_start) begin
        want_ctl  <= 1'b1;
        streaming <= 1'b0;
      end else if (wr_valid) begin
        if (want_ctl) begin
          dc_last   <= wr_byte[DC_BIT];
          streaming <= ~wr_byte[CO_BIT];
          want_ctl  <= 1'b0;
        end else begin
          if (dc_last) begin
            ram_valid <= 1'b1;
            ram_byte  <= wr_byte;
          end else begin
            cmd_valid <= 1'b1;
            cmd_byte  <= wr_byte;
          end
          if (!streaming) want_ctl <= 1'b1;
        end
      end
    end
  end

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && ram_valid)); // R6
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R6
  AST_PAIR_RETURNS_CTL: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !want_ctl && !streaming && !frame_start) |=> want_ctl); // R4
  AST_STREAM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (streaming && !want_ctl && !frame_start) |=> !want_ctl); // R5
endmodule

// File: rtl/i2c_disp_slave.sv
module i2c_disp_slave
  import i2c_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_lsb,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              ram_valid,
  output logic [BYTE_W-1:0] ram_byte,
  output logic              rd_req,
  output logic              rd_sel_ram,
  input  logic [BYTE_W-1:0] rd_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_valid, frame_start;
  logic [BYTE_W-1:0] wr_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.W(BYTE_W), .ADDR_HI(DEV_ADDR_HI)) u_eng (
    .clk(clk), .rst(rst), .addr_lsb(addr_lsb),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .rd_req(rd_req),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .frame_start(frame_start)
  );

  ctl_stream_parser #(.W(BYTE_W)) u_parse (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_valid(wr_valid), .wr_byte(wr_byte),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .ram_valid(ram_valid), .ram_byte(ram_byte), .dc_last(rd_sel_ram)
  );
endmodule

// File: tb/tb_i2c_disp_slave.sv
module tb_i2c_disp_slave;
  localparam int Q = 6;
  localparam logic [6:0] BASE_ADDR = 7'b0111100;

  logic clk = 1'b0, rst = 1'b1, addr_lsb = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, cmd_valid, ram_valid, rd_req, rd_sel_ram, sda_bus;
  logic [7:0] cmd_byte, ram_byte, rd_data;

  int n_cmp = 0, n_bad = 0, rd_cnt = 0;
  logic [8:0] got_a [0:1023];
  logic [8:0] exp_a [0:1023];
  int got_n = 0, exp_n = 0;
  logic [7:0] tx_buf [0:15];
  bit m_dc = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_disp_slave dut (
    .clk(clk), .rst(rst), .addr_lsb(addr_lsb), .scl_in(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .ram_valid(ram_valid), .ram_byte(ram_byte), .rd_req(rd_req),
    .rd_sel_ram(rd_sel_ram), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] rd_model(bit sel, int k);
    logic [6:0] v;
    v = 7'(k * 13 + 5);
    return {sel, v} ^ 8'h5A;
  endfunction

  assign rd_data = rd_model(rd_sel_ram, rd_cnt);

  always @(posedge clk) if (!rst && rd_req) rd_cnt <= rd_cnt + 1;

  always @(negedge clk) begin
    if (cmd_valid) begin got_a[got_n] = {1'b0, cmd_byte}; got_n = got_n + 1; end
    if (ram_valid) begin got_a[got_n] = {1'b1, ram_byte}; got_n = got_n + 1; end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wcyc(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wcyc(Q); scl = 1'b1; wcyc(Q);
    sda_m = 1'b0; wcyc(Q); scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wcyc(Q); scl = 1'b1; wcyc(Q); sda_m = 1'b1; wcyc(Q);
  endtask

  task automatic put_bit(bit b);
    sda_m = b; wcyc(Q); scl = 1'b1; wcyc(Q); scl = 1'b0; wcyc(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wcyc(Q); scl = 1'b1; wcyc(Q / 2);
    b = sda_bus; wcyc(Q - Q / 2); scl = 1'b0; wcyc(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(nack);
  endtask

  // Bench model of control-byte framing (R4, R5, R6)
  task automatic model_write(int len);
    bit want_ctl = 1'b1, stream = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (want_ctl) begin
        m_dc = tx_buf[i][6]; stream = ~tx_buf[i][7]; want_ctl = 1'b0;
      end else begin
        exp_a[exp_n] = {m_dc, tx_buf[i]}; exp_n++;
        if (!stream) want_ctl = 1'b1;
      end
    end
  endtask

  task automatic compare_out(string req, int base);
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int i = base; i < exp_n && i < got_n; i++)
      chk(got_a[i] == exp_a[i], req, int'(got_a[i]), int'(exp_a[i]));
  endtask

  task automatic write_frame(logic [6:0] a7, int len, bit match, bit do_stop, string req);
    bit ack;
    int base = exp_n;
    bus_start();
    send_byte({a7, 1'b0}, ack);
    chk(ack == !match, match ? "R3 address ACK" : "R1 address NACK", ack, !match);
    for (int i = 0; i < len; i++) begin
      send_byte(tx_buf[i], ack);
      if (match) chk(ack == 1'b0, "R3 data ACK", ack, 0);
      else       chk(ack == 1'b1, "R1 ignored data", ack, 1);
    end
    if (do_stop) bus_stop();
    wcyc(4);
    if (match) model_write(len);
    compare_out(req, base);
  endtask

  task automatic read_frame(int nbytes);
    bit ack;
    logic [7:0] v, e;
    int k;
    bus_start();
    send_byte({BASE_ADDR[6:1], addr_lsb, 1'b1}, ack);
    chk(ack == 1'b0, "R7 read address ACK", ack, 0);
    for (int i = 0; i < nbytes; i++) begin
      e = rd_model(m_dc, rd_cnt - 1);
      recv_byte(v, i == nbytes - 1);
      chk(v == e, "R7 read byte", v, e);
    end
    chk(rd_sel_ram == m_dc, "R7 rd_sel_ram", rd_sel_ram, m_dc);
    k = rd_cnt;
    recv_byte(v, 1'b1);
    chk(v == 8'hFF, "R8 line released after NACK", v, 8'hFF);
    chk(rd_cnt == k, "R8 no request after NACK", rd_cnt, k);
    bus_stop();
    wcyc(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_cmp, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int len;
    logic [6:0] a7;
    seed = $urandom(32'd2024);
    wcyc(6);
    chk(sda_oe == 0 && cmd_valid == 0 && ram_valid == 0, "R9 reset outputs", sda_oe, 0);
    rst = 1'b0;
    wcyc(4);
    chk(sda_oe == 0 && rd_req == 0 && rd_sel_ram == 0, "R9 after reset", rd_sel_ram, 0);

    // R4: pairs with Co=1, alternating routes, then a stream to RAM (R5)
    tx_buf[0] = 8'h80; tx_buf[1] = 8'hA1; tx_buf[2] = 8'hC0; tx_buf[3] = 8'hB2;
    tx_buf[4] = 8'h40; tx_buf[5] = 8'h11; tx_buf[6] = 8'h80; tx_buf[7] = 8'hC3;
    write_frame(BASE_ADDR, 8, 1'b1, 1'b1, "R4 R6 pair framing");

    // R5: Co=0 command stream with bytes that look like control bytes
    tx_buf[0] = 8'h00; tx_buf[1] = 8'hC0; tx_buf[2] = 8'h80; tx_buf[3] = 8'h7F;
    write_frame(BASE_ADDR, 4, 1'b1, 1'b1, "R5 command stream");

    // R7/R8: last route was command -> status read
    read_frame(3);

    // R1: wrong address ignored, then strap changes the matching address
    tx_buf[0] = 8'h40; tx_buf[1] = 8'h55;
    write_frame(BASE_ADDR | 7'd1, 2, 1'b0, 1'b1, "R1 lsb mismatch");
    addr_lsb = 1'b1;
    write_frame(BASE_ADDR | 7'd1, 2, 1'b1, 1'b1, "R1 lsb strap match");
    write_frame(BASE_ADDR, 2, 1'b0, 1'b1, "R1 old address ignored");
    read_frame(2);

    // R2: repeated START mid-stream restarts control parsing
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22;
    write_frame(BASE_ADDR | 7'd1, 3, 1'b1, 1'b0, "R2 before repeated start");
    tx_buf[0] = 8'h40; tx_buf[1] = 8'h33;
    write_frame(BASE_ADDR | 7'd1, 2, 1'b1, 1'b1, "R2 after repeated start");

    // Random frames of raw bytes against the model
    for (int t = 0; t < 12; t++) begin
      len = 1 + int'($urandom % 10);
      for (int i = 0; i < len; i++) tx_buf[i] = 8'($urandom);
      if ($urandom % 4 == 0) begin
        a7 = {6'b011110 ^ 6'(1 + $urandom % 63), 1'($urandom)};
        write_frame(a7, len, 1'b0, 1'b1, "R1 random foreign address");
      end else begin
        write_frame({6'b011110, addr_lsb}, len, 1'b1, 1'b1, "R4 R5 R6 random frame");
        if ($urandom % 2 == 0) read_frame(1 + int'($urandom % 3));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule